// File: doc/BRIEF.md
# Byte-Mask Word Bus Sequencer

This block turns one masked longword request into the fewest 16-bit word cycles on a narrow I/O bus. A request carries a longword address, a four-bit byte-lane mask, a read/write flag and 32 bits of write data. The mask alone decides which words are touched. The low pair of mask bits selects the even word of the longword and the high pair selects the odd word. A word whose two mask bits are both clear is never put on the bus. This matters because reading a device register can change its state, so a read of a word nobody asked for could disturb it.

Upstream, the requester sees a ready/valid pair. After the last word cycle it receives a one-cycle response that carries the assembled read data. Downstream, every word cycle is a request held until the target acknowledges it. Each cycle carries a word address, a write flag, a two-bit byte select and the write word. An unaligned longword split by an upstream unit into two masked requests costs two word cycles at byte offset 2 and three at offsets 1 and 3.

Top module: `bmseq_top`

## Requirements
- R1: A request with mask 0000 produces no bus cycle, and its response is asserted in the cycle right after the request is accepted.
- R2: A word whose two mask bits are both zero is never the target of a bus cycle, for reads as well as writes.
- R3: The bus word address is the longword address shifted left by one. Bit 0 is 0 for the half selected by mask bits [1:0] and 1 for the half selected by mask bits [3:2].
- R4: When both halves are selected, the even word (bit 0 = 0) is accessed before the odd word.
- R5: During a word cycle, bus_bsel equals the two mask bits of that half, with bit 0 selecting bus data bits [7:0]. bus_write equals the request's write flag. bus_wdata is the matching 16-bit half of the write data, with the low half taken from bits [15:0].
- R6: While bus_req is high and bus_ack is low, the address, byte select and write word stay unchanged and bus_req stays high.
- R7: resp_valid is high for exactly one cycle. When bus cycles took place, that cycle is the one right after the edge at which the last bus_ack was sampled.
- R8: For a read, byte lane i of resp_rdata (bits 8i+7:8i) holds the matching byte of the word read for that half if mask bit i is set, and zero otherwise. For a write, resp_rdata is zero.
- R9: After reset, req_ready is high, and bus_req and resp_valid are low. req_ready is high only while no request is in progress, so it is low during word cycles and during the response cycle.
- R10: The number of bus cycles per request is the number of halves with a nonzero mask. For example, masks 1110 and 0111 give two cycles, and masks 0001, 0011, 1100 and 1000 give one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_lwaddr | input | ADDR_W | Longword address |
| req_mask | input | 4 | Byte-lane mask, bit i covers byte lane i |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 2*WORD_W | Write data |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 2*WORD_W | Assembled read data, unselected lanes zero |
| bus_req | output | 1 | Word cycle requested |
| bus_ack | input | 1 | Word cycle acknowledged |
| bus_waddr | output | ADDR_W+1 | Word address |
| bus_write | output | 1 | Word cycle is a write |
| bus_bsel | output | 2 | Byte select within the word |
| bus_wdata | output | WORD_W | Write word |
| bus_rdata | input | WORD_W | Read word, sampled with bus_ack |

## Verification
The bench builds the block with ADDR_W = 10, WORD_W = 16 and the zero-filling response variant. The narrow address makes it practical to hit the all-zeros and all-ones longword addresses, where the odd word address uses the top bit of bus_waddr. The bench drives all sixteen masks as reads and as writes, then a random mix. Its bus responder varies the acknowledge delay from zero to several cycles, which exercises both the hold rule and response timing after back-to-back word cycles.

// File: rtl/bmseq_pkg.sv
package bmseq_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_WORD = 2'd1,
      SEQ_RESP = 2'd2
   } seq_state_e;

   localparam int unsigned LANES      = 4;
   localparam int unsigned HALF_LANES = 2;

endpackage

// File: rtl/bmseq_plan.sv
module bmseq_plan
   import bmseq_pkg::*;
(
   input  logic [LANES-1:0] mask,
   output logic [1:0]       need
);

   for (genvar h = 0; h < 2; h++) begin : g_half
      assign need[h] = |mask[h*HALF_LANES +: HALF_LANES];
   end

endmodule

// File: rtl/bmseq_ctrl.sv
module bmseq_ctrl
   import bmseq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic [1:0] need_in,
   input  logic       bus_ack,
   output logic       req_ready,
   output logic       accept,
   output logic       cur_hi,
   output logic       bus_req,
   output logic       word_done,
   output logic       resp_valid
);

   seq_state_e state_q;
   logic [1:0] need_q;

   assign req_ready  = (state_q == SEQ_IDLE);
   assign accept     = req_ready && req_valid;
   assign bus_req    = (state_q == SEQ_WORD);
   assign word_done  = bus_req && bus_ack;
   assign resp_valid = (state_q == SEQ_RESP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         cur_hi  <= 1'b0;
         need_q  <= 2'b00;
      end else begin
         case (state_q)
            SEQ_IDLE: begin
               if (req_valid) begin
                  need_q <= need_in;
                  if (need_in == 2'b00) begin
                     state_q <= SEQ_RESP;
                  end else begin
                     state_q <= SEQ_WORD;
                     cur_hi  <= ~need_in[0];
                  end
               end
            end
            SEQ_WORD: begin
               if (bus_ack) begin
                  if (!cur_hi && need_q[1]) begin
                     cur_hi <= 1'b1;
                  end else begin
                     state_q <= SEQ_RESP;
                  end
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/bmseq_gather.sv
module bmseq_gather
   import bmseq_pkg::*;
#(
   parameter int unsigned WORD_W    = 16,
   parameter bit          ZERO_FILL = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear,
   input  logic                capture,
   input  logic                cur_hi,
   input  logic [1:0]          half_mask,
   input  logic [WORD_W-1:0]   bus_rdata,
   output logic [2*WORD_W-1:0] rdata
);

   localparam int unsigned BYTE_W = WORD_W / 2;

   logic [1:0] lane_en;

   if (ZERO_FILL) begin : g_zero_fill
      assign lane_en = half_mask;
   end else begin : g_raw_fill
      assign lane_en = 2'b11;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (clear) begin
         rdata <= '0;
      end else if (capture) begin
         for (int b = 0; b < HALF_LANES; b++) begin
            if (lane_en[b]) begin
               rdata[(32'(cur_hi) * HALF_LANES + b) * BYTE_W +: BYTE_W] <=
                  bus_rdata[b*BYTE_W +: BYTE_W];
            end
         end
      end
   end

endmodule

// File: rtl/bmseq_top.sv
module bmseq_top
   import bmseq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 28,
   parameter int unsigned WORD_W    = 16,
   parameter bit          ZERO_FILL = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [ADDR_W-1:0]   req_lwaddr,
   input  logic [3:0]          req_mask,
   input  logic                req_write,
   input  logic [2*WORD_W-1:0] req_wdata,
   output logic                resp_valid,
   output logic [2*WORD_W-1:0] resp_rdata,
   output logic                bus_req,
   input  logic                bus_ack,
   output logic [ADDR_W:0]     bus_waddr,
   output logic                bus_write,
   output logic [1:0]          bus_bsel,
   output logic [WORD_W-1:0]   bus_wdata,
   input  logic [WORD_W-1:0]   bus_rdata
);

   localparam int unsigned LW_W = 2 * WORD_W;

   if (WORD_W < 2 || (WORD_W % 2) != 0) begin : g_bad_word
      $error("bmseq_top: WORD_W must be even and at least 2");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("bmseq_top: ADDR_W must be at least 1");
   end

   logic [1:0]        need_in;
   logic              accept;
   logic              cur_hi;
   logic              word_done;
   logic [ADDR_W-1:0] addr_q;
   logic [3:0]        mask_q;
   logic              wr_q;
   logic [LW_W-1:0]   wdata_q;
   logic [1:0]        half_mask;

   bmseq_plan u_plan (
      .mask (req_mask),
      .need (need_in)
   );

   bmseq_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .need_in    (need_in),
      .bus_ack    (bus_ack),
      .req_ready  (req_ready),
      .accept     (accept),
      .cur_hi     (cur_hi),
      .bus_req    (bus_req),
      .word_done  (word_done),
      .resp_valid (resp_valid)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         mask_q  <= '0;
         wr_q    <= 1'b0;
         wdata_q <= '0;
      end else if (accept) begin
         addr_q  <= req_lwaddr;
         mask_q  <= req_mask;
         wr_q    <= req_write;
         wdata_q <= req_wdata;
      end
   end

   assign half_mask = cur_hi ? mask_q[3:2] : mask_q[1:0];
   assign bus_waddr = {addr_q, cur_hi};
   assign bus_write = wr_q;
   assign bus_bsel  = half_mask;
   assign bus_wdata = cur_hi ? wdata_q[LW_W-1:WORD_W] : wdata_q[WORD_W-1:0];

   bmseq_gather #(
      .WORD_W    (WORD_W),
      .ZERO_FILL (ZERO_FILL)
   ) u_gather (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (accept),
      .capture   (word_done && !wr_q),
      .cur_hi    (cur_hi),
      .half_mask (half_mask),
      .bus_rdata (bus_rdata),
      .rdata     (resp_rdata)
   );

endmodule

// File: rtl/bmseq_chk.sv
module bmseq_chk #(
   parameter int unsigned ADDR_W = 28,
   parameter int unsigned WORD_W = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic                req_ready,
   input logic [ADDR_W-1:0]   req_lwaddr,
   input logic [3:0]          req_mask,
   input logic                resp_valid,
   input logic                bus_req,
   input logic                bus_ack,
   input logic [ADDR_W:0]     bus_waddr,
   input logic [1:0]          bus_bsel,
   input logic [WORD_W-1:0]   bus_wdata
);

   logic [ADDR_W-1:0] cap_addr;
   logic [3:0]        cap_mask;
   logic              hi_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_addr <= '0;
         cap_mask <= '0;
         hi_seen  <= 1'b0;
      end else if (req_valid && req_ready) begin
         cap_addr <= req_lwaddr;
         cap_mask <= req_mask;
         hi_seen  <= 1'b0;
      end else if (bus_req && bus_ack && bus_waddr[0]) begin
         hi_seen  <= 1'b1;
      end
   end

   a_r2_half_selected: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> (bus_waddr[0] ? (cap_mask[3:2] != 2'b00) : (cap_mask[1:0] != 2'b00)));

   a_r3_word_address: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> (bus_waddr[ADDR_W:1] == cap_addr));

   a_r4_low_first: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_waddr[0]) |-> !hi_seen);

   a_r5_bsel_match: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> (bus_bsel == (bus_waddr[0] ? cap_mask[3:2] : cap_mask[1:0])));

   a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_waddr) && $stable(bus_bsel) && $stable(bus_wdata)));

   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid);

   a_r7_after_last_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_ack && bus_waddr[0]) |=> resp_valid);

   a_r9_not_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req || resp_valid) |-> !req_ready);

endmodule

bind bmseq_top bmseq_chk #(
   .ADDR_W (ADDR_W),
   .WORD_W (WORD_W)
) u_bmseq_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_lwaddr (req_lwaddr),
   .req_mask   (req_mask),
   .resp_valid (resp_valid),
   .bus_req    (bus_req),
   .bus_ack    (bus_ack),
   .bus_waddr  (bus_waddr),
   .bus_bsel   (bus_bsel),
   .bus_wdata  (bus_wdata)
);

// File: tb/tb_bmseq_top.sv
module tb_bmseq_top;

   localparam int unsigned AW = 10;
   localparam int unsigned WW = 16;
   localparam int unsigned LW = 2 * WW;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_lwaddr = '0;
   logic [3:0]    req_mask = '0;
   logic          req_write = 1'b0;
   logic [LW-1:0] req_wdata = '0;
   logic          resp_valid;
   logic [LW-1:0] resp_rdata;
   logic          bus_req;
   logic          bus_ack = 1'b0;
   logic [AW:0]   bus_waddr;
   logic          bus_write;
   logic [1:0]    bus_bsel;
   logic [WW-1:0] bus_wdata;
   logic [WW-1:0] bus_rdata = '0;

   bmseq_top #(.ADDR_W(AW), .WORD_W(WW), .ZERO_FILL(1'b1)) dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_lwaddr(req_lwaddr),
      .req_mask(req_mask), .req_write(req_write), .req_wdata(req_wdata),
      .resp_valid(resp_valid), .resp_rdata(resp_rdata),
      .bus_req(bus_req), .bus_ack(bus_ack), .bus_waddr(bus_waddr),
      .bus_write(bus_write), .bus_bsel(bus_bsel), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata)
   );

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   function automatic logic [WW-1:0] dev_word(logic [AW:0] w);
      return WW'(32'(w) * 32'h9E37) ^ 16'h5A3C;
   endfunction

   task automatic chk(bit ok, string tag, logic [LW-1:0] act, logic [LW-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // bus target: random acknowledge delay, read data derived from address
   int wait_cnt = 0;
   always @(negedge clk) begin
      if (bus_ack) begin
         bus_ack = 1'b0;
      end else if (bus_req) begin
         if (wait_cnt == 0) begin
            bus_ack   = 1'b1;
            bus_rdata = dev_word(bus_waddr);
            wait_cnt  = int'($urandom % 4);
         end else begin
            wait_cnt--;
         end
      end
   end

   // monitor: logs completed word cycles and hold violations
   int          cyc = 0;
   int          last_ack = -10;
   int          n_tx = 0;
   int          hold_errs = 0;
   logic        held = 1'b0;
   logic [AW:0] held_addr = '0;
   logic [1:0]  held_bsel = '0;
   logic [AW:0]   log_addr [4];
   logic [1:0]    log_bsel [4];
   logic          log_wr   [4];
   logic [WW-1:0] log_wd   [4];

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (bus_req && bus_ack) begin
         log_addr[n_tx % 4] <= bus_waddr;
         log_bsel[n_tx % 4] <= bus_bsel;
         log_wr[n_tx % 4]   <= bus_write;
         log_wd[n_tx % 4]   <= bus_wdata;
         n_tx     <= n_tx + 1;
         last_ack <= cyc;
      end
      if (held && (!bus_req || bus_waddr != held_addr || bus_bsel != held_bsel))
         hold_errs <= hold_errs + 1;
      held      <= bus_req && !bus_ack;
      held_addr <= bus_waddr;
      held_bsel <= bus_bsel;
   end

   task automatic run(logic [AW-1:0] la, logic [3:0] m, logic wr, logic [LW-1:0] wd);
      int base = n_tx;
      int hb = hold_errs;
      int guard = 0;
      int nexp;
      int ngot;
      logic [LW-1:0] exp;
      logic [WW-1:0] wlo;
      logic [WW-1:0] whi;
      @(negedge clk);
      req_lwaddr = la; req_mask = m; req_write = wr; req_wdata = wd; req_valid = 1'b1;
      chk(req_ready == 1'b1, "R9 ready when idle", LW'(req_ready), 1);
      @(negedge clk);
      req_valid = 1'b0;
      if (m != 4'b0000)
         chk(req_ready == 1'b0, "R9 not ready while busy", LW'(req_ready), 0);
      while (!resp_valid && guard < 60) begin
         @(negedge clk);
         guard++;
      end
      chk(resp_valid == 1'b1, "R7 response arrives", LW'(resp_valid), 1);
      nexp = int'(|m[1:0]) + int'(|m[3:2]);
      ngot = n_tx - base;
      chk(ngot == nexp, "R10 word cycle count", LW'(ngot), LW'(nexp));
      if (m == 4'b0000) begin
         chk(guard == 0, "R1 empty mask responds at once", LW'(guard), 0);
      end else begin
         chk(cyc == last_ack + 1, "R7 response right after last ack", LW'(cyc - last_ack), 1);
      end
      if (ngot == nexp) begin
         for (int i = 0; i < nexp; i++) begin
            logic h;
            logic [AW:0] a;
            logic [1:0] hm;
            h  = (i == 1) ? 1'b1 : ~(|m[1:0]);
            a  = log_addr[(base + i) % 4];
            hm = a[0] ? m[3:2] : m[1:0];
            chk(hm != 2'b00, "R2 no cycle on empty half", LW'(a), LW'({la, h}));
            chk(a[AW:1] == la, "R3 word address", LW'(a), LW'({la, h}));
            chk(a[0] == h, "R4 low word first", LW'(a[0]), LW'(h));
            chk(log_bsel[(base + i) % 4] == (h ? m[3:2] : m[1:0]), "R5 byte select",
                LW'(log_bsel[(base + i) % 4]), LW'(h ? m[3:2] : m[1:0]));
            chk(log_wr[(base + i) % 4] == wr, "R5 write flag", LW'(log_wr[(base + i) % 4]), LW'(wr));
            if (wr)
               chk(log_wd[(base + i) % 4] == (h ? wd[LW-1:WW] : wd[WW-1:0]), "R5 write word",
                   LW'(log_wd[(base + i) % 4]), LW'(h ? wd[LW-1:WW] : wd[WW-1:0]));
         end
      end
      wlo = dev_word({la, 1'b0});
      whi = dev_word({la, 1'b1});
      exp = '0;
      if (!wr) begin
         if (m[0]) exp[7:0]   = wlo[7:0];
         if (m[1]) exp[15:8]  = wlo[15:8];
         if (m[2]) exp[23:16] = whi[7:0];
         if (m[3]) exp[31:24] = whi[15:8];
      end
      chk(resp_rdata == exp, "R8 response data", resp_rdata, exp);
      chk(hold_errs == hb, "R6 request held until ack", LW'(hold_errs - hb), 0);
      @(negedge clk);
      chk(resp_valid == 1'b0, "R7 response lasts one cycle", LW'(resp_valid), 0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1, "R9 reset ready", LW'(req_ready), 1);
      chk(bus_req == 1'b0, "R9 reset bus idle", LW'(bus_req), 0);
      chk(resp_valid == 1'b0, "R9 reset no response", LW'(resp_valid), 0);
      rst_n = 1'b1;
      // directed: every mask, read and write, at both address extremes
      for (int m = 0; m < 16; m++) begin
         run('0, 4'(m), 1'b0, '0);
         run('1, 4'(m), 1'b0, '0);
         run(AW'(m * 37), 4'(m), 1'b1, 32'hC0DE_0000 | 32'(m));
      end
      // directed: unaligned longword split pairs at offsets 1, 2, 3
      run(AW'(100), 4'b1110, 1'b0, '0); run(AW'(101), 4'b0001, 1'b0, '0);
      run(AW'(200), 4'b1100, 1'b0, '0); run(AW'(201), 4'b0011, 1'b0, '0);
      run(AW'(300), 4'b1000, 1'b0, '0); run(AW'(301), 4'b0111, 1'b0, '0);
      // random mix
      for (int i = 0; i < 400; i++) begin
         run(AW'($urandom), 4'($urandom), 1'($urandom), $urandom);
      end
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      #1_000_000;
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

endmodule